// File: doc/BRIEF.md
# Dual-Read Sine/Cosine Lookup Generator

This block converts a phase into a sine and cosine pair. A single full-cycle sine table is held in a read-only memory that has two synchronous read ports. One port reads at the phase itself and gives the sine. The other port reads a quarter turn further on and gives the cosine. Because both outputs come from one table, only one table is stored.

The phase comes from one of two sources. In accumulator mode, an internal phase accumulator adds a programmable tuning word on every accepted sample. The table address is taken from the accumulator's upper bits, and its lower bits are discarded. In direct mode, the caller supplies the table address on a phase input. The table is filled at elaboration by an integer arithmetic function, so no external file is needed. The table size follows from a target spurious-free range given in dB.

Top module: `quad_sine_lut`

## Requirements
- R1: A synchronous reset clears the phase accumulator and the output valid flag. The first accumulator-driven sample after reset reads phase 0, giving sine 0 and cosine +A, where A = 2^(AMP_W-1)-1. The table contents are not affected by reset.
- R2: For table address p, the sine output is A*sin(2*pi*p/2^ADDR_W) rounded, within one LSB, as signed two's complement.
- R3: The cosine output is the table entry at address p + 2^ADDR_W/4 modulo the table size. This address is formed by adding one, modulo four, to the two top address bits.
- R4: The sine and cosine outputs for a sample, together with out_valid, appear exactly two clock edges after the edge that accepts in_valid. out_valid is low on the cycles that follow an edge where in_valid was low.
- R5: While in_valid is low, the sine and cosine outputs hold their values and the accumulator does not advance, whatever the phase and tuning inputs do.
- R6: With use_acc high, each accepted sample uses the top ADDR_W bits of the accumulator as the address. The accumulator then grows by tune_word, modulo 2^ACC_W.
- R7: With use_acc low, phase_in is the address and the accumulator keeps its value.
- R8: Neither output ever reaches the most negative code -2^(AMP_W-1). The peaks are +A and -A.
- R9: The table address width is ADDR_W = ceil(SFDR_DB / 6), so the table holds 2^ADDR_W entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept a sample on this edge |
| use_acc | input | 1 | 1: address from accumulator, 0: address from phase_in |
| tune_word | input | ACC_W | Accumulator increment per accepted sample |
| phase_in | input | ADDR_W | Direct table address |
| out_valid | output | 1 | Sine and cosine outputs carry a new sample |
| sin_out | output | AMP_W | Signed sine amplitude |
| cos_out | output | AMP_W | Signed cosine amplitude |

## Verification
The bench builds the block with SFDR_DB=48, ACC_W=12 and AMP_W=12. This gives a 256-entry table, a peak of 2047, and four truncated accumulator bits. With the table this small, the quadrant edges (0, 64, 128, 192), the last entry 255, and the points just either side of a quadrant are all easy to hit. The 12-bit accumulator wraps within a handful of samples at a tuning word of 1000, so the modulo behaviour and the discarded low bits both show in a short run. Expected amplitudes come from real-valued sine and cosine in the bench, not from the integer series used in the design.

// File: rtl/quad_sine_pkg.sv
package quad_sine_pkg;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // phase bits needed for a spurious-free range in dB: ceil(db / 6)
  function automatic int phase_bits_for_range(input int range_db);
    return (range_db + 5) / 6;
  endfunction

  // sin(2*pi*m/n) in Q30, valid for 0 <= m <= n/4, by odd power series
  function automatic longint sine_q30(input longint m, input longint n);
    longint x;
    longint term;
    longint sum;
    x    = (PI_Q30 * 2 * m) / n;
    term = x;
    sum  = x;
    for (int k = 1; k <= 7; k++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // signed amplitude of table entry idx for a 2^addr_w table
  function automatic int sine_sample(input int idx, input int addr_w, input int amp_w);
    longint n;
    longint quad;
    longint rem;
    longint m;
    longint peak;
    longint mag;
    n    = longint'(1) << addr_w;
    quad = (longint'(idx) >> (addr_w - 2)) & 3;
    rem  = longint'(idx) & (n / 4 - 1);
    m    = quad[0] ? (n / 4 - rem) : rem;
    peak = (longint'(1) << (amp_w - 1)) - 1;
    mag  = (sine_q30(m, n) * peak + (longint'(1) << 29)) >>> 30;
    if (mag > peak) mag = peak;
    if (mag < 0) mag = 0;
    return quad[1] ? -int'(mag) : int'(mag);
  endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (adv) acc_q <= acc_q + tune;
  end

  assign acc = acc_q;

  // accumulator keeps its value on cycles without an accumulator step
  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc_q)); // R5

endmodule

// File: rtl/lut_addr_stage.sv
module lut_addr_stage #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              use_acc,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ADDR_W-1:0] phase_in,
  output logic [ADDR_W-1:0] sin_addr,
  output logic [ADDR_W-1:0] cos_addr,
  output logic              stage_valid
);

  localparam int QTR = (1 << ADDR_W) / 4;

  // quarter-turn advance: bump the two top bits, modulo four
  function automatic logic [ADDR_W-1:0] quarter_ahead(input logic [ADDR_W-1:0] a);
    logic [1:0] top;
    top = a[ADDR_W-1 -: 2] + 2'd1;
    return {top, a[ADDR_W-3:0]};
  endfunction

  logic [ADDR_W-1:0] pick_addr;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;

  // upper accumulator bits form the address; low bits are dropped
  assign pick_addr = use_acc ? acc[ACC_W-1 -: ADDR_W] : phase_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) addr_q <= pick_addr;
    end
  end

  assign sin_addr    = addr_q;
  assign cos_addr    = quarter_ahead(addr_q);
  assign stage_valid = vld_q;

  // cosine address sits one quarter of the table past the sine address
  AST_QUARTER_GAP: assert property (@(posedge clk) disable iff (rst)
    (cos_addr - sin_addr) == ADDR_W'(QTR)); // R3

endmodule

// File: rtl/sine_rom_dp.sv
module sine_rom_dp #(
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr_a,
  input  logic [ADDR_W-1:0]       addr_b,
  output logic signed [AMP_W-1:0] data_a,
  output logic signed [AMP_W-1:0] data_b
);

  import quad_sine_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [AMP_W-1:0] tbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    localparam int VAL = sine_sample(gi, ADDR_W, AMP_W);
    assign tbl[gi] = AMP_W'(VAL);
  end

  logic signed [AMP_W-1:0] rd_a_q;
  logic signed [AMP_W-1:0] rd_b_q;

  // two read ports on one table, registered, no reset on data
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_a_q <= tbl[addr_a];
      rd_b_q <= tbl[addr_b];
    end
  end

  assign data_a = rd_a_q;
  assign data_b = rd_b_q;

  // read data holds while no read is enabled
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_a_q) && $stable(rd_b_q))); // R5

endmodule

// File: rtl/quad_sine_lut.sv
module quad_sine_lut #(
  parameter int SFDR_DB = 72,
  parameter int ACC_W   = 32,
  parameter int AMP_W   = 16,
  localparam int ADDR_W = quad_sine_pkg::phase_bits_for_range(SFDR_DB) // R9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    use_acc,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic [ADDR_W-1:0]       phase_in,
  output logic                    out_valid,
  output logic signed [AMP_W-1:0] sin_out,
  output logic signed [AMP_W-1:0] cos_out
);

  localparam logic signed [AMP_W-1:0] NEG_LIMIT = {1'b1, {(AMP_W-1){1'b0}}};

  logic [ACC_W-1:0]  acc_val;
  logic              acc_step;
  logic [ADDR_W-1:0] sin_addr;
  logic [ADDR_W-1:0] cos_addr;
  logic              stage_valid;
  logic              out_vld_q;

  assign acc_step = in_valid & use_acc; // R6, R7

  phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk  (clk),
    .rst  (rst),
    .adv  (acc_step),
    .tune (tune_word),
    .acc  (acc_val)
  );

  lut_addr_stage #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .use_acc     (use_acc),
    .acc         (acc_val),
    .phase_in    (phase_in),
    .sin_addr    (sin_addr),
    .cos_addr    (cos_addr),
    .stage_valid (stage_valid)
  );

  sine_rom_dp #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (stage_valid),
    .addr_a (sin_addr),
    .addr_b (cos_addr),
    .data_a (sin_out),
    .data_b (cos_out)
  );

  always_ff @(posedge clk) begin
    if (rst) out_vld_q <= 1'b0;
    else out_vld_q <= stage_valid;
  end

  assign out_valid = out_vld_q;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R4
  AST_VALID_GAP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sin_out != NEG_LIMIT && cos_out != NEG_LIMIT)); // R8

endmodule

// File: tb/quad_sine_lut_bench.sv
`timescale 1ns/1ps
module quad_sine_lut_bench;

  localparam int SFDR = 48;
  localparam int ACCW = 12;
  localparam int AMPW = 12;
  localparam int AW   = 8;     // ceil(48/6)
  localparam int N    = 256;
  localparam int PEAK = 2047;
  localparam int NV   = 14;
  localparam int VEC [NV] = '{0, 32, 64, 96, 128, 160, 192, 224, 255, 1, 63, 65, 127, 200};

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_valid = 1'b0;
  logic                   use_acc = 1'b0;
  logic [ACCW-1:0]        tune_word = '0;
  logic [AW-1:0]          phase_in = '0;
  logic                   out_valid;
  logic signed [AMPW-1:0] sin_out;
  logic signed [AMPW-1:0] cos_out;

  int total = 0;
  int bad   = 0;
  int acc_m = 0;
  int exp_ph [16];

  always #2.5 clk = ~clk;

  quad_sine_lut #(.SFDR_DB(SFDR), .ACC_W(ACCW), .AMP_W(AMPW)) u_quad_sine_lut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_acc(use_acc),
    .tune_word(tune_word), .phase_in(phase_in),
    .out_valid(out_valid), .sin_out(sin_out), .cos_out(cos_out)
  );

  function automatic int ref_sin(input int p);
    return int'(PEAK * $sin(2.0 * 3.141592653589793 * p / N));
  endfunction
  function automatic int ref_cos(input int p);
    return int'(PEAK * $cos(2.0 * 3.141592653589793 * p / N));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic check_pair(input int p);
    int es, ec, as_v, ac_v;
    es = ref_sin(p); ec = ref_cos(p);
    as_v = int'(sin_out); ac_v = int'(cos_out);
    chk((as_v - es) <= 1 && (es - as_v) <= 1, "R2", $sformatf("sin p=%0d", p), as_v, es);
    chk((ac_v - ec) <= 1 && (ec - ac_v) <= 1, "R3", $sformatf("cos p=%0d", p), ac_v, ec);
    chk(out_valid == 1'b1, "R4", "out_valid", int'(out_valid), 1);
  endtask

  // pipelined stream: drive sample i, check sample i-2 on the same negedge
  task automatic stream(input int cnt, input bit acc_mode, input int tw);
    use_acc = acc_mode;
    tune_word = ACCW'(tw);
    for (int i = 0; i < cnt + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check_pair(exp_ph[i-2]);
      if (i < cnt) begin
        in_valid = 1'b1;
        if (acc_mode) begin
          exp_ph[i] = acc_m >> (ACCW - AW); // R6: top bits only
          acc_m = (acc_m + tw) % (1 << ACCW);
          phase_in = AW'(i * 37 + 5);        // ignored in this mode
        end else begin
          phase_in = AW'(exp_ph[i]);
        end
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    acc_m = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic signed [AMPW-1:0] hs, hc;
    do_reset();

    // table walk, direct mode, back to back
    for (int i = 0; i < NV; i++) exp_ph[i] = VEC[i];
    stream(NV, 1'b0, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "out_valid after stream", int'(out_valid), 0);

    // exact extremes and last entry
    for (int i = 0; i < 4; i++) exp_ph[i] = 64 * i;
    stream(1, 1'b0, 0); chk(sin_out == 0 && cos_out == PEAK, "R2", "p=0", int'(sin_out), 0);
    exp_ph[0] = 64;  stream(1, 1'b0, 0); chk(int'(sin_out) == PEAK, "R2", "p=64 peak", int'(sin_out), PEAK);
    exp_ph[0] = 192; stream(1, 1'b0, 0); chk(int'(sin_out) == -PEAK, "R8", "p=192 floor", int'(sin_out), -PEAK);
    exp_ph[0] = 128; stream(1, 1'b0, 0); chk(int'(cos_out) == -PEAK, "R8", "p=128 cos floor", int'(cos_out), -PEAK);
    exp_ph[0] = 255; stream(1, 1'b0, 0);
    chk(int'(sin_out) == ref_sin(255), "R9", "table size 256, p=255", int'(sin_out), ref_sin(255));

    // R5: idle cycles hold outputs whatever phase_in does
    hs = sin_out; hc = cos_out;
    for (int k = 0; k < 3; k++) begin
      phase_in = AW'(77 + k);
      tune_word = ACCW'(500);
      @(negedge clk);
      chk(sin_out == hs && cos_out == hc, "R5", "hold sin", int'(sin_out), int'(hs));
      chk(out_valid == 1'b0, "R4", "no valid when idle", int'(out_valid), 0);
    end

    // R4: single pulse latency
    @(negedge clk); use_acc = 1'b0; phase_in = 8'd40; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4", "valid one edge early", int'(out_valid), 0);
    @(negedge clk); chk(out_valid == 1'b1, "R4", "valid after two edges", int'(out_valid), 1);
    @(negedge clk); chk(out_valid == 1'b0, "R4", "valid single cycle", int'(out_valid), 0);

    // R1 + R6: accumulator from reset
    do_reset();
    stream(1, 1'b1, 163);
    chk(sin_out == 0 && cos_out == PEAK, "R1", "first acc sample phase 0", int'(sin_out), 0);
    stream(9, 1'b1, 163);

    // R5: idle does not advance accumulator; R7: direct sample leaves it
    repeat (3) @(negedge clk);
    exp_ph[0] = 9; stream(1, 1'b0, 0);
    stream(3, 1'b1, 163); // R7: continues from model value

    // R6: wrap with large tuning word
    do_reset();
    stream(8, 1'b1, 1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule